// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator

This block gathers interrupt pulses from a set of peripherals, each with up to eight lines, and condenses them into one upstream interrupt. Every line pulse sets a sticky status bit in its peripheral. Software clears status bits by writing ones. Each peripheral has a configuration register that holds an accumulate-enable bit and the number of the execution environment that owns it. A peripheral counts as active when any of its status bits is set and its enable is on. Active peripherals show up in summary words: there is one set of words per environment, with one bit per peripheral and 32 peripherals to a word.

Software uses the block as a two-level tree. On an interrupt, it reads the summary words of its environment and walks the set bits from the lowest upward. For each peripheral found, it reads that peripheral's status word and handles the lines from the lowest upward. It then writes ones to the clear register.

Only one environment drives the upstream interrupt pin. It is chosen by a parameter, and the pin is a registered OR of that environment's summary bits. The other environments' summary words can still be read through the register port.

Top module: `irqagg_top`

## Requirements
- R1: After reset, every status bit, every enable bit and every owner field is zero, `irq_out` is 0 and `reg_rdata` is 0.
- R2: A pulse on line k of peripheral p sets bit k of the status word read at 0x600 + 4·p. The bit stays set until it is cleared.
- R3: A write to 0xA00 + 4·p clears each status bit of peripheral p whose write-data bit is 1. Write-data bits that are 0 leave their status bits unchanged.
- R4: When a line pulse and a clear of the same bit fall in the same cycle, the bit ends up set.
- R5: The configuration register at 0x200 + 4·p holds the accumulate enable in bit 0 and the owning environment in bits 10:8. It reads back those fields, and all other bits read as 0.
- R6: Bit k of the summary word at 0x20·m + 4·n is 1 exactly when peripheral 32·n + k has a status bit set, is enabled, and is owned by environment m.
- R7: A peripheral whose enable is 0 still latches status, but it does not appear in any summary word and does not raise `irq_out`.
- R8: `irq_out` is the OR of all summary bits of environment HOST_ENV, registered once. It follows a change of state one clock later.
- R9: Summary words for environment numbers of NUM_ENV or above, summary words beyond the last peripheral, and registers of peripheral indices that do not exist all read as 0. Writes to the status region change nothing.
- R10: Pulses on different lines and on different peripherals accumulate independently of one another.
- R11: `reg_rdata` is loaded only on the clock edge at which `reg_rd` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_irq | input | NUM_PERIPH·LINES | One-cycle interrupt pulses. Line k of peripheral p is at bit p·LINES + k |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq_out | output | 1 | Upstream interrupt for environment HOST_ENV |

## Verification
The bench builds the block with its default parameters: 64 peripherals, eight lines each, six environments, and environment 0 driving the pin. With 64 peripherals there are two real summary words per environment. The empty words 2 to 7, environment numbers 6 and 7, and peripheral indices from 64 to 255 can therefore all be reached through legal addresses. Moving a peripheral between environment 0 and environments 1 and 2 shows that the routing to each environment's summary view is correct, and that the pin follows only the host environment.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
   localparam int unsigned ADDR_W  = 12;
   localparam int unsigned DATA_W  = 32;
   localparam int unsigned SUM_W   = 32;
   localparam int unsigned OWNER_W = 3;
   localparam int unsigned MAX_PER = 256;

   typedef enum logic [2:0] {
      RG_SUM,
      RG_CFG,
      RG_STS,
      RG_CLR,
      RG_NONE
   } region_e;

   localparam logic [ADDR_W-1:0] CFG_BASE = 12'h200;
   localparam logic [ADDR_W-1:0] STS_BASE = 12'h600;
   localparam logic [ADDR_W-1:0] CLR_BASE = 12'hA00;
   localparam logic [ADDR_W-1:0] END_BASE = 12'hE00;

   function automatic region_e decode_region(input logic [ADDR_W-1:0] a);
      if (a < CFG_BASE)      return RG_SUM;
      else if (a < STS_BASE) return RG_CFG;
      else if (a < CLR_BASE) return RG_STS;
      else if (a < END_BASE) return RG_CLR;
      else                   return RG_NONE;
   endfunction
endpackage

// File: rtl/irqagg_periph.sv
module irqagg_periph
   import irqagg_pkg::*;
#(
   parameter int unsigned LINES = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LINES-1:0]   line_pulse,
   input  logic               cfg_wr,
   input  logic               cfg_en,
   input  logic [OWNER_W-1:0] cfg_owner,
   input  logic               clr_wr,
   input  logic [LINES-1:0]   clr_mask,
   output logic [LINES-1:0]   status,
   output logic               acc_en,
   output logic [OWNER_W-1:0] owner,
   output logic               active
);
   logic [LINES-1:0] kill;

   assign kill = clr_wr ? clr_mask : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= '0;
         acc_en <= 1'b0;
         owner  <= '0;
      end else begin
         status <= (status & ~kill) | line_pulse;
         if (cfg_wr) begin
            acc_en <= cfg_en;
            owner  <= cfg_owner;
         end
      end
   end

   assign active = acc_en & (|status);

   p_pulse_wins_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (|line_pulse) |=> ((status & $past(line_pulse)) == $past(line_pulse)));

   p_clear_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && |(clr_mask & ~line_pulse)) |=> ((status & $past(clr_mask & ~line_pulse)) == '0));

   p_sticky_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_wr && line_pulse == '0) |=> $stable(status));
endmodule

// File: rtl/irqagg_summary.sv
module irqagg_summary
   import irqagg_pkg::*;
#(
   parameter int unsigned NUM_PERIPH = 64,
   parameter int unsigned NUM_ENV    = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_PERIPH-1:0]         active,
   input  logic [NUM_PERIPH*OWNER_W-1:0] owner_flat,
   output logic [NUM_ENV*NUM_PERIPH-1:0] sum_flat
);
   for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_per
      logic [NUM_ENV-1:0] column;
      for (genvar e = 0; e < NUM_ENV; e++) begin : g_env
         assign column[e] = active[p] &&
            (owner_flat[p*OWNER_W +: OWNER_W] == OWNER_W'(e));
         assign sum_flat[e*NUM_PERIPH + p] = column[e];
      end

      p_one_env_r6 : assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(column));
   end
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
   import irqagg_pkg::*;
#(
   parameter int unsigned NUM_PERIPH = 64,
   parameter int unsigned LINES      = 8,
   parameter int unsigned NUM_ENV    = 6,
   parameter int unsigned HOST_ENV   = 0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_PERIPH*LINES-1:0] line_irq,
   input  logic                        reg_wr,
   input  logic                        reg_rd,
   input  logic [11:0]                 reg_addr,
   input  logic [31:0]                 reg_wdata,
   output logic [31:0]                 reg_rdata,
   output logic                        irq_out
);
   localparam int unsigned NUM_WORDS = (NUM_PERIPH + SUM_W - 1) / SUM_W;

   if (NUM_PERIPH < 1 || NUM_PERIPH > MAX_PER) begin : g_bad_per
      $error("NUM_PERIPH out of range");
   end
   if (LINES < 1 || LINES > 8) begin : g_bad_lines
      $error("LINES must be 1..8");
   end
   if (NUM_ENV < 1 || NUM_ENV > 8) begin : g_bad_env
      $error("NUM_ENV must be 1..8");
   end
   if (HOST_ENV >= NUM_ENV) begin : g_bad_host
      $error("HOST_ENV must be below NUM_ENV");
   end
   if (NUM_WORDS > 8) begin : g_bad_words
      $error("summary words exceed address window");
   end

   region_e           region;
   logic [ADDR_W-1:0] offs;
   logic [7:0]        pidx;

   always_comb begin
      region = decode_region(reg_addr);
      unique case (region)
         RG_CFG:  offs = reg_addr - CFG_BASE;
         RG_STS:  offs = reg_addr - STS_BASE;
         RG_CLR:  offs = reg_addr - CLR_BASE;
         default: offs = reg_addr;
      endcase
      pidx = offs[9:2];
   end

   logic [NUM_PERIPH-1:0]         active_vec;
   logic [NUM_PERIPH-1:0]         en_vec;
   logic [NUM_PERIPH*OWNER_W-1:0] owner_flat;
   logic [NUM_PERIPH*LINES-1:0]   status_flat;
   logic [NUM_ENV*NUM_PERIPH-1:0] sum_flat;

   for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_slice
      logic hit;
      assign hit = (pidx == 8'(p));

      irqagg_periph #(.LINES(LINES)) i_periph (
         .clk        (clk),
         .rst_n      (rst_n),
         .line_pulse (line_irq[p*LINES +: LINES]),
         .cfg_wr     (reg_wr && region == RG_CFG && hit),
         .cfg_en     (reg_wdata[0]),
         .cfg_owner  (reg_wdata[8 +: OWNER_W]),
         .clr_wr     (reg_wr && region == RG_CLR && hit),
         .clr_mask   (reg_wdata[LINES-1:0]),
         .status     (status_flat[p*LINES +: LINES]),
         .acc_en     (en_vec[p]),
         .owner      (owner_flat[p*OWNER_W +: OWNER_W]),
         .active     (active_vec[p])
      );
   end

   irqagg_summary #(.NUM_PERIPH(NUM_PERIPH), .NUM_ENV(NUM_ENV)) i_summary (
      .clk        (clk),
      .rst_n      (rst_n),
      .active     (active_vec),
      .owner_flat (owner_flat),
      .sum_flat   (sum_flat)
   );

   logic [DATA_W-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      unique case (region)
         RG_SUM: begin
            for (int k = 0; k < SUM_W; k++) begin
               int env;
               int per;
               env = int'(reg_addr[7:5]);
               per = int'(reg_addr[4:2]) * SUM_W + k;
               if (env < NUM_ENV && per < NUM_PERIPH)
                  rd_next[k] = sum_flat[env*NUM_PERIPH + per];
            end
         end
         RG_CFG: begin
            if (int'(pidx) < NUM_PERIPH) begin
               rd_next[0]            = en_vec[pidx];
               rd_next[8 +: OWNER_W] = owner_flat[int'(pidx)*OWNER_W +: OWNER_W];
            end
         end
         RG_STS: begin
            if (int'(pidx) < NUM_PERIPH)
               rd_next[LINES-1:0] = status_flat[int'(pidx)*LINES +: LINES];
         end
         default: rd_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata <= '0;
         irq_out   <= 1'b0;
      end else begin
         if (reg_rd) reg_rdata <= rd_next;
         irq_out <= |sum_flat[HOST_ENV*NUM_PERIPH +: NUM_PERIPH];
      end
   end

   p_irq_quiet_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !(|$past(en_vec)) |-> !irq_out);

   p_irq_nostatus_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      !(|$past(status_flat)) |-> !irq_out);

   p_rdata_hold_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/test_irqagg_top.sv
module test_irqagg_top;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 64;
   localparam int NL = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NP*NL-1:0]  line_irq = '0;
   logic              reg_wr = 1'b0;
   logic              reg_rd = 1'b0;
   logic [11:0]       reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              irq_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irqagg_top #(.NUM_PERIPH(NP), .LINES(NL), .NUM_ENV(6), .HOST_ENV(0)) i_irqagg_top (
      .clk(clk), .rst_n(rst_n), .line_irq(line_irq), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk);
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(posedge clk);
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic pulse(input int p, input logic [7:0] lines);
      @(negedge clk);
      line_irq[p*NL +: NL] = lines;
      @(posedge clk);
      @(negedge clk);
      line_irq = '0;
   endtask

   function automatic logic [11:0] a_sum(input int m, input int n);
      return 12'(32*m + 4*n);
   endfunction
   function automatic logic [11:0] a_cfg(input int p); return 12'(12'h200 + 4*p); endfunction
   function automatic logic [11:0] a_sts(input int p); return 12'(12'h600 + 4*p); endfunction
   function automatic logic [11:0] a_clr(input int p); return 12'(12'hA00 + 4*p); endfunction

   task automatic t_reset;
      logic [31:0] v;
      check("R1 irq_out", {31'b0, irq_out}, 32'h0);
      check("R1 rdata", reg_rdata, 32'h0);
      reg_read(a_sts(0), v);  check("R1 status", v, 32'h0);
      reg_read(a_cfg(5), v);  check("R1 cfg", v, 32'h0);
      reg_read(a_sum(0, 0), v); check("R1 summary", v, 32'h0);
   endtask

   task automatic t_latch;
      logic [31:0] v;
      pulse(3, 8'h04);
      pulse(3, 8'h40);
      pulse(5, 8'h01);
      reg_read(a_sts(3), v); check("R2 R10 status p3", v, 32'h44);
      reg_read(a_sts(5), v); check("R10 status p5", v, 32'h01);
      reg_read(a_sum(0, 0), v); check("R7 summary disabled", v, 32'h0);
      check("R7 irq disabled", {31'b0, irq_out}, 32'h0);
   endtask

   task automatic t_enable;
      logic [31:0] v;
      reg_write(a_cfg(3), 32'h1);
      check("R8 irq latency", {31'b0, irq_out}, 32'h0);
      @(posedge clk); @(negedge clk);
      check("R8 irq set", {31'b0, irq_out}, 32'h1);
      reg_read(a_cfg(3), v); check("R5 cfg readback", v, 32'h1);
      reg_read(a_sum(0, 0), v); check("R6 summary env0", v, 32'h8);
      reg_write(a_cfg(3), 32'hFFFF_F201);
      reg_read(a_cfg(3), v); check("R5 cfg masked", v, 32'h201);
      reg_read(a_sum(0, 0), v); check("R6 env0 after move", v, 32'h0);
      reg_read(a_sum(2, 0), v); check("R6 env2 word0", v, 32'h8);
      check("R8 irq non-host", {31'b0, irq_out}, 32'h0);
      reg_write(a_cfg(3), 32'h1);
   endtask

   task automatic t_clear;
      logic [31:0] v;
      reg_write(a_clr(3), 32'h04);
      reg_read(a_sts(3), v); check("R3 partial clear", v, 32'h40);
      reg_write(a_clr(3), 32'h00);
      reg_read(a_sts(3), v); check("R3 zero mask", v, 32'h40);
      reg_write(a_clr(3), 32'hFF);
      reg_read(a_sts(3), v); check("R3 full clear", v, 32'h0);
      check("R8 irq cleared", {31'b0, irq_out}, 32'h0);
   endtask

   task automatic t_race;
      logic [31:0] v;
      @(negedge clk);
      line_irq[40*NL +: NL] = 8'h02;
      reg_wr = 1'b1; reg_addr = a_clr(40); reg_wdata = 32'h02;
      @(posedge clk);
      @(negedge clk);
      line_irq = '0; reg_wr = 1'b0;
      reg_read(a_sts(40), v); check("R4 pulse beats clear", v, 32'h02);
   endtask

   task automatic t_word1;
      logic [31:0] v;
      reg_write(a_cfg(40), 32'h1);
      pulse(33, 8'h01);
      reg_write(a_cfg(33), 32'h101);
      reg_read(a_sum(0, 1), v); check("R6 env0 word1", v, 32'h100);
      reg_read(a_sum(1, 1), v); check("R6 env1 word1", v, 32'h2);
      check("R8 irq word1", {31'b0, irq_out}, 32'h1);
   endtask

   task automatic t_bounds;
      logic [31:0] v;
      reg_read(a_sum(0, 2), v); check("R9 word beyond", v, 32'h0);
      reg_read(a_sum(6, 1), v); check("R9 env beyond", v, 32'h0);
      reg_read(a_cfg(100), v);  check("R9 periph beyond", v, 32'h0);
      reg_write(a_sts(40), 32'h0);
      reg_read(a_sts(40), v);   check("R9 status write ignored", v, 32'h02);
      reg_read(a_sts(5), v);
      @(negedge clk); @(negedge clk);
      check("R11 rdata holds", reg_rdata, 32'h01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latch();
      t_enable();
      t_clear();
      t_race();
      t_word1();
      t_bounds();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end
endmodule